// File: doc/BRIEF.md
# Single-Precision Overflow and Underflow Result Handler

This block sits after the rounding step of a single-precision floating-point datapath. It takes a value that has already been rounded to 24 significant bits, with an exponent whose range is unbounded. It works out whether that value lies outside the range a single-precision word can hold. It then either packs the value normally or applies the response that the overflow or underflow masks select. A masked overflow turns into a saturated value, and the rounding mode and the sign choose that value. A masked tiny result is shifted right into the denormal range and rounded again. Either unmasked condition raises a flag and marks the result as one that must not be written.

The exponent input carries the single-precision bias, so the value equals `1.f * 2^(exp_i - 127)`. Results come out one clock after the input and are marked by `valid_o`. Classifying the operands and doing the arithmetic belong to earlier stages.

Top module: `sp_range_fixup`

## Requirements
- R1: When 1 <= exp_i <= 254, result_o = {sign_i, exp_i[7:0], sig_i[22:0]}, oe_o = ue_o = 0, wr_block_o = 0, and pe_o equals inexact_i.
- R2: Overflow is detected when exp_i >= 255, which is a rounded magnitude of at least 2^128. It sets oe_o and clears ue_o.
- R3: Rounding mode encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. With overflow masked and mode 00, the result is infinity of the input sign: 0x7F800000 or 0xFF800000.
- R4: With overflow masked and mode 01, a positive result becomes 0x7F7FFFFF, the largest finite value (exponent field 0xFE, all-ones fraction). A negative result becomes 0xFF800000.
- R5: With overflow masked and mode 10, a positive result becomes 0x7F800000 and a negative result becomes 0xFF7FFFFF.
- R6: With overflow masked and mode 11, the result is the largest finite value of the input sign: 0x7F7FFFFF or 0xFF7FFFFF.
- R7: A masked overflow always sets pe_o alongside oe_o.
- R8: A result is tiny when exp_i <= 0, which is a magnitude below 2^-126. With underflow masked, the 31-bit magnitude field of result_o equals sig_i * 2^(exp_i-1), rounded to an integer in the current mode. The shift saturates, so very small inputs round to 0 or to one unit. A carry out of the fraction produces the smallest normal value.
- R9: With underflow masked, ue_o and pe_o are both set exactly when the denormalized result is inexact: either shifted-out bits are nonzero or inexact_i is set. An exact tiny result gives ue_o = 0 and pe_o = 0.
- R10: With the relevant mask clear, an overflow sets oe_o and a tiny result sets ue_o, whether or not the result is exact. In both cases wr_block_o is 1 and pe_o equals inexact_i.
- R11: Outputs are registered and appear one cycle after valid_i, with valid_o set in that cycle. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input value present |
| sign_i | input | 1 | Sign of the rounded result |
| exp_i | input | EXP_W | Signed biased exponent, unbounded range |
| sig_i | input | 24 | Rounded significand with explicit leading one |
| rmode_i | input | 2 | Rounding mode (see R3) |
| ovf_mask_i | input | 1 | 1 = overflow masked |
| unf_mask_i | input | 1 | 1 = underflow masked |
| inexact_i | input | 1 | Earlier rounding discarded nonzero bits |
| valid_o | output | 1 | Result present |
| result_o | output | 32 | Single-precision result |
| oe_o | output | 1 | Overflow flag |
| ue_o | output | 1 | Underflow flag |
| pe_o | output | 1 | Inexact flag |
| wr_block_o | output | 1 | Result must not be written (unmasked case) |

## Verification
The stimulus covers the exponent edges 254/255 and 1/0, so that an off-by-one threshold shows up as a normal value that saturates or a tiny value that passes through unchanged. All eight combinations of mode and sign are applied to masked overflow, so a swapped sign or direction yields infinity where the largest finite value belongs, or the reverse. For underflow, the bench drives exact denormals that must leave UE clear, ties that must round to even, a carry into the smallest normal value, and shifts far past the fraction width where the directed modes must yield one unit. Unmasked cases check that the block flags the result as unwritable and keeps PE tied to the incoming inexact bit.

// File: rtl/sp_range_pkg.sv
package sp_range_pkg;
  localparam int SIG_W  = 24;
  localparam int FRAC_W = SIG_W - 1;
  localparam int EF_W   = 8;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  localparam logic [EF_W-1:0]   EF_INF  = 8'hFF;
  localparam logic [EF_W-1:0]   EF_MAXF = 8'hFE;
  localparam logic [FRAC_W-1:0] FR_ONES = '1;
endpackage

// File: rtl/sp_ovf_saturate.sv
module sp_ovf_saturate
  import sp_range_pkg::*;
(
  input  logic        sign_i,
  input  rmode_e      rmode_i,
  output logic [31:0] sat_o
);
  logic to_inf;

  // infinity only when the mode rounds away from zero for this sign
  always_comb begin
    unique case (rmode_i)
      RM_NEAR: to_inf = 1'b1;
      RM_DOWN: to_inf = sign_i;
      RM_UP:   to_inf = ~sign_i;
      default: to_inf = 1'b0;
    endcase
    sat_o = to_inf ? {sign_i, EF_INF, {FRAC_W{1'b0}}}
                   : {sign_i, EF_MAXF, FR_ONES};
  end
endmodule

// File: rtl/sp_tiny_denorm.sv
module sp_tiny_denorm
  import sp_range_pkg::*;
#(
  parameter int SH_W = 5
) (
  input  logic             sign_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  rmode_e           rmode_i,
  input  logic             inexact_i,
  output logic [31:0]      den_o,
  output logic             den_inexact_o
);
  localparam int PAD   = SIG_W + 3;
  localparam int EXT_W = SIG_W + PAD;

  logic [EXT_W-1:0] ext;
  logic [SIG_W-1:0] kept;
  logic             guard, sticky, inc;
  logic [SIG_W-1:0] rnd;

  always_comb begin
    ext    = {sig_i, {PAD{1'b0}}} >> shamt_i;
    kept   = ext[EXT_W-1 -: SIG_W];
    guard  = ext[PAD-1];
    sticky = (|ext[PAD-2:0]) | inexact_i;
    unique case (rmode_i)
      RM_NEAR: inc = guard & (sticky | kept[0]);
      RM_DOWN: inc = sign_i & (guard | sticky);
      RM_UP:   inc = ~sign_i & (guard | sticky);
      default: inc = 1'b0;
    endcase
    rnd           = kept + SIG_W'(inc);
    // a carry into bit 23 lands in the exponent field: smallest normal
    den_o         = {sign_i, {(31-SIG_W){1'b0}}, rnd};
    den_inexact_o = guard | sticky;
  end
endmodule

// File: rtl/sp_range_fixup.sv
module sp_range_fixup
  import sp_range_pkg::*;
#(
  parameter int EXP_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sign_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  input  logic [1:0]              rmode_i,
  input  logic                    ovf_mask_i,
  input  logic                    unf_mask_i,
  input  logic                    inexact_i,
  output logic                    valid_o,
  output logic [31:0]             result_o,
  output logic                    oe_o,
  output logic                    ue_o,
  output logic                    pe_o,
  output logic                    wr_block_o
);
  localparam int SH_W    = 5;
  localparam int SH_MAX  = SIG_W + 2;
  localparam logic signed [EXP_W-1:0] EXP_OVF = EXP_W'(255);
  localparam logic signed [EXP_W-1:0] EXP_LOW = EXP_W'(1 - SH_MAX);

  rmode_e           rm;
  logic             is_ovf, is_tiny;
  logic [SH_W-1:0]  shamt;
  logic [31:0]      sat_w, den_w;
  logic             den_inex;
  logic [31:0]      res_d;
  logic             oe_d, ue_d, pe_d, blk_d;

  assign rm      = rmode_e'(rmode_i);
  assign is_ovf  = exp_i >= EXP_OVF;
  assign is_tiny = exp_i <= $signed(EXP_W'(0));

  always_comb begin
    if (exp_i <= EXP_LOW) shamt = SH_W'(SH_MAX);
    else                  shamt = SH_W'(EXP_W'(1) - exp_i);
  end

  sp_ovf_saturate u_sat (
    .sign_i (sign_i),
    .rmode_i(rm),
    .sat_o  (sat_w)
  );

  sp_tiny_denorm #(.SH_W(SH_W)) u_den (
    .sign_i       (sign_i),
    .sig_i        (sig_i),
    .shamt_i      (shamt),
    .rmode_i      (rm),
    .inexact_i    (inexact_i),
    .den_o        (den_w),
    .den_inexact_o(den_inex)
  );

  always_comb begin
    res_d = {sign_i, exp_i[EF_W-1:0], sig_i[FRAC_W-1:0]};
    oe_d  = 1'b0;
    ue_d  = 1'b0;
    pe_d  = inexact_i;
    blk_d = 1'b0;
    if (is_ovf) begin
      oe_d = 1'b1;
      if (ovf_mask_i) begin
        res_d = sat_w;
        pe_d  = 1'b1;
      end else begin
        blk_d = 1'b1;
      end
    end else if (is_tiny) begin
      if (unf_mask_i) begin
        res_d = den_w;
        ue_d  = den_inex;
        pe_d  = den_inex;
      end else begin
        ue_d  = 1'b1;
        blk_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      oe_o       <= 1'b0;
      ue_o       <= 1'b0;
      pe_o       <= 1'b0;
      wr_block_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o   <= res_d;
        oe_o       <= oe_d;
        ue_o       <= ue_d;
        pe_o       <= pe_d;
        wr_block_o <= blk_d;
      end
    end
  end

  p_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_ovf && !is_tiny |=> !oe_o && !ue_o && !wr_block_o
                                       && pe_o == $past(inexact_i));
  p_ovf_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_ovf |=> oe_o && !ue_o);
  p_sat_pe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_ovf && ovf_mask_i |=> pe_o && !wr_block_o);
  p_ue_pe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ue_o && !wr_block_o |-> pe_o);
  p_unmasked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_tiny && !unf_mask_i |=> ue_o && wr_block_o);
  p_valid_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
endmodule

// File: tb/sp_range_fixup_bench.sv
module sp_range_fixup_bench;
  localparam int EXP_W = 12;

  typedef struct {
    logic [31:0] res;
    logic        oe, ue, pe, blk;
    string       req;
  } exp_t;

  logic                    clk = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    valid_i = 1'b0;
  logic                    sign_i = 1'b0;
  logic signed [EXP_W-1:0] exp_i = '0;
  logic [23:0]             sig_i = '0;
  logic [1:0]              rmode_i = '0;
  logic                    ovf_mask_i = 1'b1;
  logic                    unf_mask_i = 1'b1;
  logic                    inexact_i = 1'b0;
  logic                    valid_o;
  logic [31:0]             result_o;
  logic                    oe_o, ue_o, pe_o, wr_block_o;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t sb[$];
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sp_range_fixup #(.EXP_W(EXP_W)) u_sp_range_fixup (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .sig_i(sig_i), .rmode_i(rmode_i), .ovf_mask_i(ovf_mask_i),
    .unf_mask_i(unf_mask_i), .inexact_i(inexact_i), .valid_o(valid_o),
    .result_o(result_o), .oe_o(oe_o), .ue_o(ue_o), .pe_o(pe_o),
    .wr_block_o(wr_block_o)
  );

  function automatic exp_t model(input logic s, input int e, input logic [23:0] m,
                                 input logic [1:0] rm, input logic om, input logic um,
                                 input logic ix, input string req);
    exp_t x;
    x.req = req; x.oe = 0; x.ue = 0; x.pe = ix; x.blk = 0;
    x.res = {s, e[7:0], m[22:0]};
    if (e >= 255) begin
      x.oe = 1;
      if (!om) x.blk = 1;
      else begin
        bit inf;
        x.pe = 1;
        inf = (rm == 2'd0) || (rm == 2'd1 && s) || (rm == 2'd2 && !s);
        x.res = inf ? {s, 31'h7F800000} : {s, 31'h7F7FFFFF};
      end
    end else if (e <= 0) begin
      if (!um) begin x.ue = 1; x.blk = 1; end
      else begin
        longint sh, q, rem, half;
        bit lost, up;
        sh = 1 - e; if (sh > 40) sh = 40;
        q = longint'(m) >> sh;
        rem = longint'(m) - (q << sh);
        half = longint'(1) << (sh - 1);
        lost = (rem != 0) || ix;
        case (rm)
          2'd0: up = (rem > half) || (rem == half && (ix || q[0]));
          2'd1: up = s && lost;
          2'd2: up = !s && lost;
          default: up = 0;
        endcase
        q = q + (up ? 1 : 0);
        x.res = {s, q[30:0]};
        x.ue = lost; x.pe = lost;
      end
    end
    return x;
  endfunction

  task automatic drive(input logic s, input int e, input logic [23:0] m,
                       input logic [1:0] rm, input logic om, input logic um,
                       input logic ix, input string req);
    @(negedge clk);
    valid_i = 1; sign_i = s; exp_i = EXP_W'(e); sig_i = m; rmode_i = rm;
    ovf_mask_i = om; unf_mask_i = um; inexact_i = ix;
    sb.push_back(model(s, e, m, rm, om, um, ix, req));
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per valid result
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && valid_o) begin
        if (sb.size() == 0) chk("R11", "unexpected valid_o", 1, 0);
        else begin
          exp_t x;
          x = sb.pop_front();
          chk(x.req, "wr_block", 32'(wr_block_o), 32'(x.blk));
          if (!x.blk) chk(x.req, "result", result_o, x.res);
          chk(x.req, "oe", 32'(oe_o), 32'(x.oe));
          chk(x.req, "ue", 32'(ue_o), 32'(x.ue));
          chk(x.req, "pe", 32'(pe_o), 32'(x.pe));
        end
      end
    end
  end

  initial begin
    #200000000;
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset valid", 32'(valid_o), 0);
    chk("R11", "reset result", result_o, 0);
    chk("R11", "reset flags", {28'd0, oe_o, ue_o, pe_o, wr_block_o}, 0);
    rst_ni = 1;
    // R1 normal pass-through, including edges 1 and 254
    drive(0, 127, 24'hC00000, 2'd0, 1, 1, 1, "R1");
    drive(1, 254, 24'hFFFFFF, 2'd3, 1, 1, 0, "R1");
    drive(0, 1,   24'h800000, 2'd0, 1, 1, 0, "R1");
    // R2..R6, R7: masked overflow, all modes and signs
    for (int rm = 0; rm < 4; rm++)
      for (int s = 0; s < 2; s++)
        drive(s[0], 255 + rm * 40, 24'h9ABCDE, rm[1:0], 1, 1, 0,
              rm == 0 ? "R3" : rm == 1 ? "R4" : rm == 2 ? "R5" : "R6");
    drive(0, 255, 24'h800000, 2'd0, 1, 1, 0, "R2");
    drive(1, 300, 24'h800001, 2'd3, 1, 1, 1, "R7");
    // R8/R9: masked underflow
    drive(0, 0,   24'h800000, 2'd0, 1, 1, 0, "R9");  // exact, UE clear
    drive(0, 0,   24'h800001, 2'd0, 1, 1, 0, "R8");  // tie to even, down
    drive(0, 0,   24'h800003, 2'd0, 1, 1, 0, "R8");  // tie to even, up
    drive(1, 0,   24'hFFFFFF, 2'd0, 1, 1, 0, "R8");  // carry to min normal
    drive(0, -3,  24'hABCDEF, 2'd1, 1, 1, 0, "R8");
    drive(1, -3,  24'hABCDEF, 2'd1, 1, 1, 0, "R8");
    drive(0, -3,  24'hABCDEF, 2'd2, 1, 1, 0, "R8");
    drive(1, -3,  24'hABCDEF, 2'd3, 1, 1, 0, "R8");
    drive(0, -7,  24'hF00000, 2'd3, 1, 1, 0, "R9");  // exact after shift
    drive(0, -7,  24'hF00000, 2'd3, 1, 1, 1, "R9");  // exact bits but inexact_i
    drive(0, -60, 24'h800000, 2'd2, 1, 1, 0, "R8");  // far shift, one unit
    drive(1, -60, 24'h800000, 2'd0, 1, 1, 0, "R8");  // far shift, zero
    drive(0, -22, 24'h800000, 2'd0, 1, 1, 0, "R9");  // exact smallest denormal
    // R10: unmasked
    drive(0, 260, 24'h800000, 2'd0, 0, 1, 0, "R10");
    drive(1, 255, 24'h800000, 2'd1, 0, 1, 1, "R10");
    drive(0, 0,   24'h800000, 2'd0, 1, 0, 0, "R10"); // exact but still flagged
    drive(1, -5,  24'h812345, 2'd2, 1, 0, 1, "R10");
    @(negedge clk);
    valid_i = 0;
    repeat (3) @(negedge clk);
    chk("R11", "queue drained", 32'(sb.size()), 0);
    chk("R11", "valid drops", 32'(valid_o), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule